// File: doc/BRIEF.md
# Load-Store Byte Lane Aligner

This unit sits between a 32-bit integer register path and a 32-bit little-endian, byte-addressable data memory port. For every load or store it adds a sign-extended 16-bit displacement to a base register value to form the byte address, so the reach is plus or minus 32 KB around the base. It then checks that the access is naturally aligned for its size and raises an address-error flag when it is not.

For stores it builds the byte-enable mask and copies the low byte or low halfword of the source register into every lane that could receive it. Only the lanes chosen by the two low address bits are enabled. For loads it takes the full memory word that the memory returns alongside the request and picks out the addressed byte or halfword. It then widens that value to 32 bits by sign or zero extension.

The data path is combinational. A parameter adds one output register stage, which makes every result appear one clock after its request.

Top module: `lsu_lane_align`

## Requirements
- R1: `o_addr` equals `i_base` plus `i_offset` taken as a two's-complement 16-bit value and sign-extended, computed modulo 2^32.
- R2: `i_size` bits [1:0] select the access width: 00 is byte, 01 is halfword, 10 or 11 is word. Bit 2 set means an unsigned load. The codes used are B=000, H=001, W=010, BU=100 and HU=101. Bit 2 has no effect on word accesses.
- R3: `o_misalign` is 1 for a valid halfword access whose address bit 0 is 1. It is also 1 for a valid word access whose address bits [1:0] are not 00. Byte accesses never set it.
- R4: When `o_misalign` is 1, `o_byte_en` is 0000 and `o_load_data` is zero.
- R5: An aligned byte store sets only bit a[1:0] of `o_byte_en`, where a is the address. `o_wdata` holds store data bits [7:0] in all four byte lanes.
- R6: An aligned halfword store sets `o_byte_en` to 0011 when address bit 1 is 0 and to 1100 when it is 1. `o_wdata` holds store data bits [15:0] in both halves.
- R7: An aligned word store sets `o_byte_en` to 1111 and passes the store data to `o_wdata` unchanged.
- R8: A load follows little-endian lane order. The byte at address a is taken from memory word bits [8*a[1:0]+7 : 8*a[1:0]]. The halfword is taken from bits [31:16] when a[1] is 1 and from bits [15:0] when a[1] is 0. A signed load fills the upper bits with bit 7 or bit 15 of the value. An unsigned load fills them with zeros.
- R9: A load, or a cycle with `i_valid` at 0, leaves `o_byte_en` at 0000 and `o_misalign` at 0. `o_load_data` is zero except for a valid, aligned load.
- R10: With `OUT_REG`=1, each output shows the result of the request presented one clock earlier. While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low reset |
| i_valid | input | 1 | Request present |
| i_is_store | input | 1 | 1 for store, 0 for load |
| i_size | input | 3 | Width and signedness code |
| i_base | input | ADDR_W | Base register value |
| i_offset | input | OFF_W | Signed displacement |
| i_store_data | input | DATA_W | Source register for stores |
| i_load_word | input | DATA_W | Word returned by memory for this request |
| o_valid | output | 1 | Result present |
| o_addr | output | ADDR_W | Effective byte address |
| o_misalign | output | 1 | Alignment fault |
| o_byte_en | output | DATA_W/8 | Per-lane write enables |
| o_wdata | output | DATA_W | Lane-steered store data |
| o_load_data | output | DATA_W | Extended load result |

## Verification
The bench uses negative displacements, the largest positive displacement, and a base near the top of the address space that wraps around. A design that zero-extends the offset or drops the carry would produce a wrong address in these cases. It sends byte stores to each of the four lanes and halfword stores to both halves, which catches lane mix-ups and big-endian ordering. It loads bytes with bit 7 set under both signed and unsigned codes, which catches sign extension applied in the wrong place. It also sends misaligned halfword and word accesses and checks that no byte enable leaks through, and it uses the spare word codes to check that bit 2 is ignored for words.

// File: rtl/lane_pkg.sv
package lane_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10
   } acc_size_e;

   function automatic acc_size_e decode_size(input logic [2:0] code);
      case (code[1:0])
         2'b00:   return SZ_BYTE;
         2'b01:   return SZ_HALF;
         default: return SZ_WORD;
      endcase
   endfunction
endpackage

// File: rtl/lane_ea.sv
module lane_ea #(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 16
) (
   input  logic [ADDR_W-1:0] i_base,
   input  logic [OFF_W-1:0]  i_off,
   output logic [ADDR_W-1:0] o_ea
);
   localparam int EXT_W = ADDR_W - OFF_W;

   if (OFF_W >= ADDR_W) begin : g_bad_off
      $error("lane_ea: OFF_W must be narrower than ADDR_W");
   end

   logic [ADDR_W-1:0] off_ext;
   assign off_ext = {{EXT_W{i_off[OFF_W-1]}}, i_off};
   assign o_ea    = i_base + off_ext;
endmodule

// File: rtl/lane_align_chk.sv
module lane_align_chk
   import lane_pkg::*;
(
   input  acc_size_e  i_sz,
   input  logic [1:0] i_lo,
   output logic       o_mis
);
   always_comb begin
      case (i_sz)
         SZ_HALF: o_mis = i_lo[0];
         SZ_WORD: o_mis = |i_lo;
         default: o_mis = 1'b0;
      endcase
   end
endmodule

// File: rtl/lane_store_steer.sv
module lane_store_steer
   import lane_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              i_en,
   input  acc_size_e         i_sz,
   input  logic [1:0]        i_lo,
   input  logic [DATA_W-1:0] i_data,
   output logic [DATA_W/8-1:0] o_be,
   output logic [DATA_W-1:0] o_wdata
);
   localparam int LANES = DATA_W / 8;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      localparam logic [1:0] KIDX = 2'(k);
      logic pick;
      always_comb begin
         case (i_sz)
            SZ_BYTE: pick = (i_lo == KIDX);
            SZ_HALF: pick = (i_lo[1] == KIDX[1]);
            default: pick = 1'b1;
         endcase
      end
      assign o_be[k] = i_en & pick;

      always_comb begin
         case (i_sz)
            SZ_BYTE: o_wdata[8*k +: 8] = i_data[7:0];
            SZ_HALF: o_wdata[8*k +: 8] = i_data[8*(k%2) +: 8];
            default: o_wdata[8*k +: 8] = i_data[8*k +: 8];
         endcase
      end
   end
endmodule

// File: rtl/lane_load_extract.sv
module lane_load_extract
   import lane_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              i_en,
   input  acc_size_e         i_sz,
   input  logic              i_unsigned,
   input  logic [1:0]        i_lo,
   input  logic [DATA_W-1:0] i_word,
   output logic [DATA_W-1:0] o_data
);
   logic [7:0]  sel_b;
   logic [15:0] sel_h;
   logic        fill_b, fill_h;

   assign sel_b  = i_word[8*i_lo +: 8];
   assign sel_h  = i_word[16*i_lo[1] +: 16];
   assign fill_b = ~i_unsigned & sel_b[7];
   assign fill_h = ~i_unsigned & sel_h[15];

   always_comb begin
      if (!i_en) begin
         o_data = '0;
      end else begin
         case (i_sz)
            SZ_BYTE: o_data = {{(DATA_W-8){fill_b}}, sel_b};
            SZ_HALF: o_data = {{(DATA_W-16){fill_h}}, sel_h};
            default: o_data = i_word;
         endcase
      end
   end
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
   import lane_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int OFF_W   = 16,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                i_valid,
   input  logic                i_is_store,
   input  logic [2:0]          i_size,
   input  logic [ADDR_W-1:0]   i_base,
   input  logic [OFF_W-1:0]    i_offset,
   input  logic [DATA_W-1:0]   i_store_data,
   input  logic [DATA_W-1:0]   i_load_word,
   output logic                o_valid,
   output logic [ADDR_W-1:0]   o_addr,
   output logic                o_misalign,
   output logic [DATA_W/8-1:0] o_byte_en,
   output logic [DATA_W-1:0]   o_wdata,
   output logic [DATA_W-1:0]   o_load_data
);
   localparam int LANES = DATA_W / 8;

   if (DATA_W != 32) begin : g_bad_data
      $error("lsu_lane_align: only a 32-bit data port is supported");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("lsu_lane_align: ADDR_W too small");
   end

   acc_size_e         sz;
   logic [ADDR_W-1:0] c_ea;
   logic              mis_raw, c_mis, st_en, ld_en;
   logic [LANES-1:0]  c_be;
   logic [DATA_W-1:0] c_wd, c_ld;

   assign sz = decode_size(i_size);

   lane_ea #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ea (
      .i_base (i_base),
      .i_off  (i_offset),
      .o_ea   (c_ea)
   );

   lane_align_chk u_chk (
      .i_sz  (sz),
      .i_lo  (c_ea[1:0]),
      .o_mis (mis_raw)
   );

   assign c_mis = i_valid & mis_raw;
   assign st_en = i_valid & i_is_store & ~mis_raw;
   assign ld_en = i_valid & ~i_is_store & ~mis_raw;

   lane_store_steer #(.DATA_W(DATA_W)) u_st (
      .i_en    (st_en),
      .i_sz    (sz),
      .i_lo    (c_ea[1:0]),
      .i_data  (i_store_data),
      .o_be    (c_be),
      .o_wdata (c_wd)
   );

   lane_load_extract #(.DATA_W(DATA_W)) u_ld (
      .i_en       (ld_en),
      .i_sz       (sz),
      .i_unsigned (i_size[2]),
      .i_lo       (c_ea[1:0]),
      .i_word     (i_load_word),
      .o_data     (c_ld)
   );

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            o_valid     <= 1'b0;
            o_addr      <= '0;
            o_misalign  <= 1'b0;
            o_byte_en   <= '0;
            o_wdata     <= '0;
            o_load_data <= '0;
         end else begin
            o_valid     <= i_valid;
            o_addr      <= c_ea;
            o_misalign  <= c_mis;
            o_byte_en   <= c_be;
            o_wdata     <= c_wd;
            o_load_data <= c_ld;
         end
      end

      assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
         o_valid == $past(i_valid));
   end else begin : g_comb
      assign o_valid     = i_valid;
      assign o_addr      = c_ea;
      assign o_misalign  = c_mis;
      assign o_byte_en   = c_be;
      assign o_wdata     = c_wd;
      assign o_load_data = c_ld;
   end

   assert_fault_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      o_misalign |-> (o_byte_en == '0 && o_load_data == '0));

   assert_word_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (i_valid && sz == SZ_WORD && c_ea[1:0] != 2'b00) |-> c_mis);

   assert_byte_one_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (i_valid && i_is_store && sz == SZ_BYTE) |-> ($countones(c_be) == 1));

   assert_word_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (i_valid && i_is_store && sz == SZ_WORD && !c_mis) |-> (c_be == '1));

   assert_ubyte_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (i_valid && !i_is_store && i_size == 3'b100) |-> (c_ld[DATA_W-1:8] == '0));

   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !o_valid |-> (o_byte_en == '0 && !o_misalign));
endmodule

// File: tb/sim_lsu_lane_align.sv
module sim_lsu_lane_align;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        i_valid = 1'b0;
   logic        i_is_store = 1'b0;
   logic [2:0]  i_size = 3'b000;
   logic [31:0] i_base = '0;
   logic [15:0] i_offset = '0;
   logic [31:0] i_store_data = '0;
   logic [31:0] i_load_word = '0;
   logic        o_valid, o_misalign;
   logic [31:0] o_addr, o_wdata, o_load_data;
   logic [3:0]  o_byte_en;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   lsu_lane_align u0 (
      .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_is_store(i_is_store),
      .i_size(i_size), .i_base(i_base), .i_offset(i_offset),
      .i_store_data(i_store_data), .i_load_word(i_load_word),
      .o_valid(o_valid), .o_addr(o_addr), .o_misalign(o_misalign),
      .o_byte_en(o_byte_en), .o_wdata(o_wdata), .o_load_data(o_load_data)
   );

   typedef struct {
      string       tag;
      bit          st;
      logic [31:0] addr;
      bit          mis;
      logic [3:0]  be;
      logic [31:0] wd;
      logic [31:0] ld;
   } exp_t;

   exp_t sb[$];

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic exp_t model(input string tag, input bit st, input logic [2:0] code,
                                  input logic [31:0] base, input logic [15:0] off,
                                  input logic [31:0] sd, input logic [31:0] lw);
      exp_t e;
      int   w;
      logic [7:0]  b;
      logic [15:0] h;
      e.tag = tag; e.st = st;
      e.addr = base + {{16{off[15]}}, off};
      w = (code[1:0] == 2'b00) ? 1 : (code[1:0] == 2'b01) ? 2 : 4;
      e.mis = (w == 2 && e.addr[0]) || (w == 4 && e.addr[1:0] != 2'b00);
      e.be = 4'b0000; e.wd = '0; e.ld = '0;
      if (st) begin
         if (w == 1) begin
            e.be = 4'b0001 << e.addr[1:0];
            e.wd = {4{sd[7:0]}};
         end else if (w == 2) begin
            e.be = e.addr[1] ? 4'b1100 : 4'b0011;
            e.wd = {2{sd[15:0]}};
         end else begin
            e.be = 4'b1111;
            e.wd = sd;
         end
         if (e.mis) e.be = 4'b0000;
      end else if (!e.mis) begin
         b = 8'(lw >> (8 * e.addr[1:0]));
         h = e.addr[1] ? lw[31:16] : lw[15:0];
         if (w == 1)      e.ld = code[2] ? {24'h0, b} : {{24{b[7]}}, b};
         else if (w == 2) e.ld = code[2] ? {16'h0, h} : {{16{h[15]}}, h};
         else             e.ld = lw;
      end
      return e;
   endfunction

   task automatic acc(input string tag, input bit st, input logic [2:0] code,
                      input logic [31:0] base, input logic [15:0] off,
                      input logic [31:0] sd, input logic [31:0] lw);
      @(negedge clk);
      i_valid = 1'b1; i_is_store = st; i_size = code;
      i_base = base; i_offset = off; i_store_data = sd; i_load_word = lw;
      sb.push_back(model(tag, st, code, base, off, sd, lw));
   endtask

   task automatic idle_store_check();
      @(negedge clk);
      i_valid = 1'b0; i_is_store = 1'b1; i_size = 3'b010;
      i_base = 32'h0000_0001; i_offset = 16'h0;
      @(negedge clk);
      chk(o_byte_en == 4'b0000 && !o_misalign && !o_valid, "R9", "idle be/mis",
          {27'h0, o_valid, o_byte_en}, 32'h0);
   endtask

   always @(negedge clk) begin
      if (rst_n && o_valid) begin
         if (sb.size() == 0) begin
            chk(1'b0, "R10", "unexpected result", 32'h1, 32'h0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk(o_addr == e.addr, e.tag, "addr", o_addr, e.addr);
            chk(o_misalign == e.mis, e.tag, "misalign", {31'h0, o_misalign}, {31'h0, e.mis});
            chk(o_byte_en == e.be, e.tag, "byte_en", {28'h0, o_byte_en}, {28'h0, e.be});
            if (e.st && !e.mis) chk(o_wdata == e.wd, e.tag, "wdata", o_wdata, e.wd);
            if (!e.st) chk(o_load_data == e.ld, e.tag, "load_data", o_load_data, e.ld);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL R10 watchdog: actual %h expected %h", 32'h0, 32'h1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(o_valid == 0 && o_addr == 0 && o_byte_en == 0 && o_load_data == 0 && o_wdata == 0,
          "R10", "reset outputs", {o_addr[27:0], o_byte_en}, 32'h0);
      rst_n = 1'b1;

      // R1 address formation
      acc("R1", 1'b0, 3'b010, 32'h0000_1000, 16'hFFFC, 32'h0, 32'hCAFE_F00D);
      acc("R1", 1'b0, 3'b100, 32'h0000_0001, 16'h7FFF, 32'h0, 32'h0000_00A5);
      acc("R1", 1'b1, 3'b001, 32'hFFFF_FFFE, 16'h0004, 32'h0000_BEEF, 32'h0);
      // R5 byte stores, every lane
      for (int k = 0; k < 4; k++)
         acc("R5", 1'b1, 3'b000, 32'h0000_2000, 16'(k), 32'h1234_56A5, 32'h0);
      // R6 halfword stores
      acc("R6", 1'b1, 3'b001, 32'h0000_3000, 16'h0000, 32'h1234_C3D4, 32'h0);
      acc("R6", 1'b1, 3'b101, 32'h0000_3000, 16'h0002, 32'h1234_C3D4, 32'h0);
      // R7 word store
      acc("R7", 1'b1, 3'b010, 32'h0000_4004, 16'hFFFC, 32'hDEAD_BEEF, 32'h0);
      // R3/R4 misaligned
      acc("R4", 1'b1, 3'b001, 32'h0000_3000, 16'h0001, 32'hFFFF_FFFF, 32'h0);
      acc("R4", 1'b1, 3'b001, 32'h0000_3000, 16'h0003, 32'hFFFF_FFFF, 32'h0);
      acc("R3", 1'b1, 3'b010, 32'h0000_4000, 16'h0002, 32'hFFFF_FFFF, 32'h0);
      acc("R4", 1'b0, 3'b001, 32'h0000_5000, 16'h0001, 32'h0, 32'h8081_F27F);
      acc("R3", 1'b0, 3'b000, 32'h0000_5000, 16'h0003, 32'h0, 32'h8081_F27F);
      // R8 loads
      acc("R8", 1'b0, 3'b000, 32'h0000_5000, 16'h0000, 32'h0, 32'h8081_F27F);
      acc("R8", 1'b0, 3'b000, 32'h0000_5000, 16'h0001, 32'h0, 32'h8081_F27F);
      acc("R8", 1'b0, 3'b100, 32'h0000_5000, 16'h0001, 32'h0, 32'h8081_F27F);
      acc("R8", 1'b0, 3'b000, 32'h0000_5000, 16'h0003, 32'h0, 32'h8081_F27F);
      acc("R8", 1'b0, 3'b100, 32'h0000_5000, 16'h0002, 32'h0, 32'h8081_F27F);
      acc("R8", 1'b0, 3'b001, 32'h0000_5000, 16'h0002, 32'h0, 32'h8081_F27F);
      acc("R8", 1'b0, 3'b101, 32'h0000_5000, 16'h0002, 32'h0, 32'h8081_F27F);
      acc("R8", 1'b0, 3'b001, 32'h0000_5000, 16'h0000, 32'h0, 32'h8081_F27F);
      // R2 spare word codes ignore signedness
      acc("R2", 1'b0, 3'b110, 32'h0000_5000, 16'h0000, 32'h0, 32'h8081_F27F);
      acc("R2", 1'b1, 3'b011, 32'h0000_6000, 16'h0008, 32'h0102_0304, 32'h0);
      acc("R2", 1'b0, 3'b111, 32'h0000_5000, 16'h0002, 32'h0, 32'h8081_F27F);
      // R9 idle cycle with store controls set
      idle_store_check();
      repeat (3) @(negedge clk);
      chk(sb.size() == 0, "R10", "drain", 32'(sb.size()), 32'h0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule